// File: doc/BRIEF.md
# Remote DMA Command Slot Trigger

This block collects the four arguments that describe a remote copy into one of several command slots. The arguments are byte count, source address, destination address and acknowledgement address. Software stores each argument with a plain word write, in any order and with any spacing. A per-slot flag nibble records which arguments have arrived. When the nibble is full the slot is armed. It then waits for the segmenter, which is shared by all slots.

The segmenter accepts one armed slot at a time, choosing the lowest index. In the same cycle it clears that slot's flags, so software can load the slot again at once. It then emits packet descriptors on a ready/valid port. Each descriptor carries its own source, destination and acknowledgement address, its byte count, the slot it came from and a last-packet marker. A receiver can therefore place every packet in memory by itself and acknowledge it with its own size.

Top module: `rdma_cmd_slots`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into argument `wr_field` of slot `wr_slot` and sets that argument's flag. The field codes are 0 = byte count (low 17 bits used), 1 = source, 2 = destination and 3 = acknowledgement address.
- R2: No descriptor is produced while any of a slot's four flags is clear, however long the gap between writes and whatever their order.
- R3: The fourth flag is set at rising edge k. If the segmenter is idle, `pkt_valid` stays low after edge k and goes high after edge k+1.
- R4: Each descriptor's `pkt_bytes` equals the smaller of MAXP and the bytes still to send. `pkt_last` is high exactly on the descriptor that finishes the transfer.
- R5: Across one transfer, source and destination each advance by the previous descriptor's `pkt_bytes`. The acknowledgement address and `pkt_slot` stay fixed.
- R6: A slot armed with a byte count of zero produces no descriptor and is released.
- R7: A slot's flags clear in the cycle it is accepted. Three further writes to it afterwards do not trigger a transfer.
- R8: Writing an argument again before the trigger replaces its value, keeps its flag set and causes no extra trigger.
- R9: While `pkt_valid` is high and `pkt_ready` is low, the valid signal and every descriptor field hold their values.
- R10: Slots operate independently. When several are armed, the lowest-numbered one is served first, and `pkt_slot` names the source slot.
- R11: The largest count, 65536 bytes, is sent as 65536/MAXP full packets. A count equal to MAXP is sent as a single packet that is also the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Argument write strobe |
| wr_slot | input | 2 | Target slot index |
| wr_field | input | 2 | Argument code (see R1) |
| wr_data | input | 32 | Argument value |
| pkt_valid | output | 1 | Descriptor available |
| pkt_ready | input | 1 | Downstream takes the descriptor |
| pkt_slot | output | 2 | Slot the transfer came from |
| pkt_src | output | 32 | Source address of this packet |
| pkt_dst | output | 32 | Destination address of this packet |
| pkt_ack | output | 32 | Acknowledgement address |
| pkt_bytes | output | 7 | Payload bytes in this packet |
| pkt_last | output | 1 | Final packet of the transfer |

## Verification
The assertions assume that `wr_slot` always names an existing slot. They also assume that byte counts never exceed 65536, so the remainder arithmetic stays inside 17 bits. They place no restriction on `pkt_ready`, which may stall at any point. The stimulus uses slot indices 0 to 3 only and counts no larger than 65536. It deasserts ready on chosen packets to exercise the hold behaviour.

// File: rtl/rdma_cmd_slots.sv
module rdma_cmd_slots #(
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  parameter int SZW   = 17,
  parameter int MAXP  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NSLOT)-1:0]   wr_slot,
  input  logic [1:0]                 wr_field,
  input  logic [AW-1:0]              wr_data,
  output logic                       pkt_valid,
  input  logic                       pkt_ready,
  output logic [$clog2(NSLOT)-1:0]   pkt_slot,
  output logic [AW-1:0]              pkt_src,
  output logic [AW-1:0]              pkt_dst,
  output logic [AW-1:0]              pkt_ack,
  output logic [$clog2(MAXP+1)-1:0]  pkt_bytes,
  output logic                       pkt_last
);
  localparam int SW  = $clog2(NSLOT);
  localparam int PBW = $clog2(MAXP+1);

  logic [AW-1:0] arg_q [NSLOT][4];
  logic [3:0]    vld_q [NSLOT];
  logic [NSLOT-1:0] armed;

  logic          busy;
  logic [SZW-1:0] rem;
  logic [AW-1:0] src_q, dst_q, ack_q;
  logic [SW-1:0] slot_q;
  logic          take;
  logic [SW-1:0] sel;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= '0;
        for (int f = 0; f < 4; f++) arg_q[s][f] <= '0;
      end else begin
        if (take && sel == SW'(s)) vld_q[s] <= '0;
        if (wr_en && wr_slot == SW'(s)) begin
          vld_q[s][wr_field] <= 1'b1;
          arg_q[s][wr_field] <= wr_data;
        end
      end
    end
    assign armed[s] = &vld_q[s];
  end

  always_comb begin
    sel = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (armed[i]) sel = SW'(i);
  end
  assign take = !busy && |armed;

  wire [SZW-1:0] new_size = arg_q[sel][0][SZW-1:0];

  assign pkt_valid = busy;
  assign pkt_last  = rem <= SZW'(MAXP);
  assign pkt_bytes = pkt_last ? rem[PBW-1:0] : PBW'(MAXP);
  assign pkt_src   = src_q;
  assign pkt_dst   = dst_q;
  assign pkt_ack   = ack_q;
  assign pkt_slot  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rem <= '0; src_q <= '0; dst_q <= '0; ack_q <= '0; slot_q <= '0;
    end else if (take) begin
      busy   <= new_size != '0;
      rem    <= new_size;
      src_q  <= arg_q[sel][1];
      dst_q  <= arg_q[sel][2];
      ack_q  <= arg_q[sel][3];
      slot_q <= sel;
    end else if (busy && pkt_ready) begin
      rem   <= rem - SZW'(pkt_bytes);
      src_q <= src_q + AW'(pkt_bytes);
      dst_q <= dst_q + AW'(pkt_bytes);
      if (pkt_last) busy <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dst) && $stable(pkt_src)
      && $stable(pkt_bytes) && $stable(pkt_ack) && $stable(pkt_last));
  a_r4_bytes_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_bytes != '0 && pkt_bytes <= PBW'(MAXP));
  a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && !pkt_last |=>
      pkt_valid && pkt_dst == $past(pkt_dst) + AW'($past(pkt_bytes)) && $stable(pkt_ack) && $stable(pkt_slot));
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !armed[$past(sel)]);
endmodule

// File: tb/tb_rdma_cmd_slots.sv
`timescale 1ns/1ps
module tb_rdma_cmd_slots;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_slot = 0, wr_field = 0; logic [31:0] wr_data = 0;
  logic pkt_ready = 0, pkt_valid, pkt_last;
  logic [1:0] pkt_slot; logic [31:0] pkt_src, pkt_dst, pkt_ack; logic [6:0] pkt_bytes;
  int nchk = 0, nbad = 0, cyc = 0;

  rdma_cmd_slots dut (.clk, .rst_n, .wr_en, .wr_slot, .wr_field, .wr_data, .pkt_valid,
    .pkt_ready, .pkt_slot, .pkt_src, .pkt_dst, .pkt_ack, .pkt_bytes, .pkt_last);

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin nbad++; $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp); end
  endtask

  task automatic wr(int slot, int field, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_slot = 2'(slot); wr_field = 2'(field); wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic arm(int slot, logic [31:0] sz, logic [31:0] s, logic [31:0] d, logic [31:0] a);
    wr(slot, 0, sz); wr(slot, 1, s); wr(slot, 2, d); wr(slot, 3, a);
  endtask

  task automatic wait_valid(string req);
    int n = 0;
    @(negedge clk);
    while (!pkt_valid && n < 100) begin @(negedge clk); n++; end
    chk(pkt_valid, req, "pkt_valid timeout", pkt_valid, 1);
  endtask

  task automatic expect_xfer(int slot, int size, logic [31:0] src, logic [31:0] dst,
                             logic [31:0] ack, int stall_every, bit idle_after, string req);
    int rem = size, k = 0;
    logic [31:0] s = src, d = dst;
    while (rem > 0) begin
      int b = rem > 64 ? 64 : rem;
      wait_valid(req);
      if (!pkt_valid) return;
      chk(pkt_slot == 2'(slot), "R10", "pkt_slot", pkt_slot, slot);
      chk(pkt_bytes == 7'(b), "R4", "pkt_bytes", pkt_bytes, b);
      chk(pkt_last == (rem <= 64), "R4", "pkt_last", pkt_last, rem <= 64);
      chk(pkt_src == s, "R5", "pkt_src", pkt_src, s);
      chk(pkt_dst == d, "R5", "pkt_dst", pkt_dst, d);
      chk(pkt_ack == ack, "R5", "pkt_ack", pkt_ack, ack);
      if (stall_every != 0 && k % stall_every == 0) begin
        @(negedge clk);
        chk(pkt_valid && pkt_dst == d && pkt_bytes == 7'(b) && pkt_src == s, "R9", "held descriptor dst", pkt_dst, d);
      end
      pkt_ready = 1; @(posedge clk); #1 pkt_ready = 0;
      rem -= b; s += b; d += b; k++;
    end
    if (idle_after) begin
      @(negedge clk);
      chk(!pkt_valid, req, "pkt_valid after last packet", pkt_valid, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!pkt_valid, "R3", "pkt_valid after reset", pkt_valid, 0);
  endtask

  task automatic t_basic_timing;
    wr(0, 3, 32'hA000); wr(0, 0, 200); wr(0, 2, 32'h8000_0000);
    wr(0, 1, 32'h1000);
    @(negedge clk); chk(!pkt_valid, "R3", "valid one edge after arming", pkt_valid, 0);
    @(negedge clk); chk(pkt_valid, "R3", "valid two edges after arming", pkt_valid, 1);
    expect_xfer(0, 200, 32'h1000, 32'h8000_0000, 32'hA000, 0, 1, "R1");
  endtask

  task automatic t_gap;
    wr(1, 2, 32'h300); wr(1, 1, 32'h200);
    repeat (10) @(negedge clk);
    wr(1, 3, 32'h400);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk(!pkt_valid, "R2", "valid with three flags", pkt_valid, 0);
    end
    wr(1, 0, 70);
    expect_xfer(1, 70, 32'h200, 32'h300, 32'h400, 0, 1, "R2");
  endtask

  task automatic t_zero_and_clear;
    arm(2, 0, 32'h11, 32'h22, 32'h33);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk(!pkt_valid, "R6", "valid for zero count", pkt_valid, 0);
    end
    wr(2, 1, 32'h50); wr(2, 2, 32'h60); wr(2, 3, 32'h70);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk(!pkt_valid, "R7", "valid after three rewrites", pkt_valid, 0);
    end
    wr(2, 0, 10);
    expect_xfer(2, 10, 32'h50, 32'h60, 32'h70, 0, 1, "R7");
  endtask

  task automatic t_overwrite;
    wr(3, 0, 100); wr(3, 2, 32'h900); wr(3, 0, 130); wr(3, 2, 32'hC00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(!pkt_valid, "R8", "valid after repeated writes", pkt_valid, 0);
    end
    wr(3, 1, 32'h40); wr(3, 3, 32'h44);
    expect_xfer(3, 130, 32'h40, 32'hC00, 32'h44, 0, 1, "R8");
  endtask

  task automatic t_stall;
    arm(0, 250, 32'h2000, 32'h3000, 32'h4000);
    expect_xfer(0, 250, 32'h2000, 32'h3000, 32'h4000, 1, 1, "R9");
  endtask

  task automatic t_multi;
    arm(2, 300, 32'h100, 32'h200, 32'h300);
    wr(1, 0, 20);  wr(0, 1, 32'hB0); wr(1, 1, 32'hA0); wr(0, 0, 90);
    wr(1, 2, 32'hA1); wr(0, 3, 32'hB3); wr(1, 3, 32'hA3); wr(0, 2, 32'hB2);
    expect_xfer(2, 300, 32'h100, 32'h200, 32'h300, 0, 0, "R10");
    expect_xfer(0, 90, 32'hB0, 32'hB2, 32'hB3, 0, 0, "R10");
    expect_xfer(1, 20, 32'hA0, 32'hA1, 32'hA3, 0, 1, "R10");
  endtask

  task automatic t_bounds;
    arm(1, 64, 32'h0, 32'h10, 32'h20);
    expect_xfer(1, 64, 32'h0, 32'h10, 32'h20, 0, 1, "R11");
    arm(3, 65536, 32'h1_0000, 32'h7_0000, 32'h5);
    expect_xfer(3, 65536, 32'h1_0000, 32'h7_0000, 32'h5, 0, 1, "R11");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_basic_timing(); t_gap(); t_zero_and_clear(); t_overwrite();
    t_stall(); t_multi(); t_bounds();
    finish_run();
  end
endmodule